// File: doc/BRIEF.md
# Periodic Second-Length Calibration Unit

This block derives a one-pulse-per-second tick from an oscillator-rate clock enable. It can also correct the rate of that tick by changing the length of a few chosen seconds. It keeps its own place inside a repeating calibration period of 64 minutes. A sign bit and a 5-bit magnitude choose how many minutes in that period carry one adjusted second, and in which direction the second is changed. The block also gives a minute strobe, which the time-of-day counters further down the chain use.

A nominal second lasts `NOM_CYCLES` enabled oscillator cycles. A magnitude of N adjusts the first second of each of the first 2N minutes of the period. With the sign set, the adjusted second is `SHORT_DELTA` cycles shorter, so the clock gains. With the sign clear, it is `LONG_DELTA` cycles longer, so the clock loses. The sign and magnitude are captured only at the start of a period, so one period never mixes two settings.

Top module: `sec_trim_unit`

## Requirements
- R1: While `rst_n` is low, both `sec_tick` and `min_tick` are 0, all counters clear, and the sign and magnitude present on the inputs are captured. These captured values govern the first calibration period after reset.
- R2: A nominal second ends after exactly `NOM_CYCLES` clock edges with `osc_en` high. Edges with `osc_en` low do not advance the count.
- R3: `sec_tick` is a single-clock pulse, registered on the edge that completes a second. `min_tick` pulses on the same edge as every `SEC_PER_MIN`-th tick and never without a tick.
- R4: A calibration period spans 64 minutes. With magnitude 0 it lasts exactly 64·`SEC_PER_MIN`·`NOM_CYCLES` enabled cycles.
- R5: With magnitude N > 0, the first second of minutes 0 to 2N−1 of the period is adjusted. Every other second of the period has nominal length.
- R6: With `cal_sign` = 1, an adjusted second lasts `NOM_CYCLES` − `SHORT_DELTA`, so the period is 2N·`SHORT_DELTA` cycles shorter than nominal.
- R7: With `cal_sign` = 0, an adjusted second lasts `NOM_CYCLES` + `LONG_DELTA`, so the period is 2N·`LONG_DELTA` cycles longer than nominal.
- R8: At the largest magnitude, 31, minutes 0 to 61 are adjusted. Minutes 62 and 63 always stay nominal.
- R9: A change to `cal_sign` or `cal_mag` in the middle of a period leaves that period unaltered. The new values apply from the next period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_en | input | 1 | Oscillator-rate clock enable; each high cycle counts once |
| cal_sign | input | 1 | 1 = shorten adjusted seconds (gain), 0 = lengthen (lose) |
| cal_mag | input | MAG_W | Magnitude N; the first 2N minutes of each period are adjusted |
| sec_tick | output | 1 | One-clock pulse at the end of each second |
| min_tick | output | 1 | One-clock pulse at the end of each minute, coincident with a tick |

## Verification
The bench runs four full periods back to back. The settings are, in order: gain with magnitude 1 (captured in reset), gain with magnitude 6, lose with magnitude 31, and no trim. The total cycle count of each period tells the shortening apart from the lengthening and scales with N. The length of each single second shows which minutes were touched, including the boundary at minute 2N and the minutes 62 and 63 that are never adjusted. The settings change early in the middle of each period, which shows that changes wait for the next period. A separate run with the enable toggling on alternate cycles shows that only enabled cycles count.

// File: rtl/sec_trim_pkg.sv
package sec_trim_pkg;

    typedef enum logic {
        TRIM_LOSE = 1'b0,
        TRIM_GAIN = 1'b1
    } trim_dir_e;

    function automatic int unsigned trimmed_len(trim_dir_e dir, int unsigned nom,
                                                int unsigned cut, int unsigned add);
        return (dir == TRIM_GAIN) ? (nom - cut) : (nom + add);
    endfunction

endpackage

// File: rtl/sec_trim_divider.sv
module sec_trim_divider #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] len,
    output logic             wrap,
    output logic             tick
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        wrap      = en && (st_q.cnt == len - 1'b1);
        st_d.tick = wrap;
        if (en) begin
            st_d.cnt = wrap ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(st_q.cnt));

    // R2
    count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < len);

    // R3
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tick |=> !st_q.tick);

endmodule

// File: rtl/sec_trim_position.sv
module sec_trim_position
    import sec_trim_pkg::*;
#(
    parameter int NOM_CYCLES    = 32768,
    parameter int SHORT_DELTA   = 128,
    parameter int LONG_DELTA    = 256,
    parameter int SEC_PER_MIN   = 60,
    parameter int MIN_PER_CYCLE = 64,
    parameter int MAG_W         = 5,
    parameter int CNT_W         = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap,
    input  logic             sign_in,
    input  logic [MAG_W-1:0] mag_in,
    output logic [CNT_W-1:0] len,
    output logic             min_tick
);
    localparam int SEC_W = $clog2(SEC_PER_MIN);
    localparam int MIN_W = $clog2(MIN_PER_CYCLE);
    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);
    localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(MIN_PER_CYCLE - 1);
    localparam logic [CNT_W-1:0] LEN_NOM  = CNT_W'(NOM_CYCLES);
    localparam logic [CNT_W-1:0] LEN_GAIN =
        CNT_W'(trimmed_len(TRIM_GAIN, NOM_CYCLES, SHORT_DELTA, LONG_DELTA));
    localparam logic [CNT_W-1:0] LEN_LOSE =
        CNT_W'(trimmed_len(TRIM_LOSE, NOM_CYCLES, SHORT_DELTA, LONG_DELTA));
    localparam int TOP_TRIM_MIN = 2 * ((1 << MAG_W) - 1);

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [MIN_W-1:0] mn;
        logic             sign;
        logic [MAG_W-1:0] mag;
        logic             mtick;
    } pos_state_t;

    pos_state_t st_d, st_q;
    logic last_sec, last_min, period_end, altered;

    always_comb begin
        st_d       = st_q;
        st_d.mtick = 1'b0;
        last_sec   = (st_q.sec == SEC_LAST);
        last_min   = (st_q.mn == MIN_LAST);
        period_end = wrap && last_sec && last_min;
        if (wrap) begin
            st_d.sec = last_sec ? '0 : st_q.sec + 1'b1;
            if (last_sec) begin
                st_d.mtick = 1'b1;
                st_d.mn    = last_min ? '0 : st_q.mn + 1'b1;
            end
        end
        if (period_end) begin
            st_d.sign = sign_in;
            st_d.mag  = mag_in;
        end
        altered = (st_q.sec == '0) && (32'(st_q.mn) < (32'(st_q.mag) << 1));
        if (!altered)          len = LEN_NOM;
        else if (st_q.sign)    len = LEN_GAIN;
        else                   len = LEN_LOSE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.sign <= sign_in;
            st_q.mag  <= mag_in;
        end else begin
            st_q <= st_d;
        end
    end

    assign min_tick = st_q.mtick;

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !period_end |=> $stable({st_q.sign, st_q.mag}));

    // R8
    tail_nominal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(st_q.mn) >= TOP_TRIM_MIN) |-> (len == LEN_NOM));

endmodule

// File: rtl/sec_trim_unit.sv
module sec_trim_unit #(
    parameter int NOM_CYCLES    = 32768,
    parameter int SHORT_DELTA   = 128,
    parameter int LONG_DELTA    = 256,
    parameter int SEC_PER_MIN   = 60,
    parameter int MIN_PER_CYCLE = 64,
    parameter int MAG_W         = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_en,
    input  logic             cal_sign,
    input  logic [MAG_W-1:0] cal_mag,
    output logic             sec_tick,
    output logic             min_tick
);
    localparam int CNT_W = $clog2(NOM_CYCLES + LONG_DELTA + 1);

    logic [CNT_W-1:0] sec_len;
    logic             sec_wrap;

    sec_trim_divider #(
        .CNT_W (CNT_W)
    ) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (osc_en),
        .len   (sec_len),
        .wrap  (sec_wrap),
        .tick  (sec_tick)
    );

    sec_trim_position #(
        .NOM_CYCLES    (NOM_CYCLES),
        .SHORT_DELTA   (SHORT_DELTA),
        .LONG_DELTA    (LONG_DELTA),
        .SEC_PER_MIN   (SEC_PER_MIN),
        .MIN_PER_CYCLE (MIN_PER_CYCLE),
        .MAG_W         (MAG_W),
        .CNT_W         (CNT_W)
    ) pos_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap     (sec_wrap),
        .sign_in  (cal_sign),
        .mag_in   (cal_mag),
        .len      (sec_len),
        .min_tick (min_tick)
    );

    // R3
    minute_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        min_tick |-> sec_tick);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!sec_tick && !min_tick));

endmodule

// File: tb/sec_trim_unit_tb_top.sv
`timescale 1ns/1ps
module sec_trim_unit_tb_top;
    localparam int NOM  = 260;
    localparam int CUT  = 128;
    localparam int ADD  = 256;
    localparam int SPM  = 2;
    localparam int MPC  = 64;
    localparam int SPC  = SPM * MPC;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b0;
    logic       cal_sign = 1'b0;
    logic [4:0] cal_mag = '0;
    logic       sec_tick, min_tick;

    int n_tests = 0, n_fail = 0;
    bit finished = 1'b0;

    int cyc = 0, last_tick = 0, last_end = 0, sec_idx = 0;
    int cycles_done = 0, min_cnt = 0, ticks_since_min = 0, cyc_total = 0;
    int sec_len [0:255];

    always #4 clk = ~clk;

    sec_trim_unit #(
        .NOM_CYCLES (NOM), .SHORT_DELTA (CUT), .LONG_DELTA (ADD),
        .SEC_PER_MIN (SPM), .MIN_PER_CYCLE (MPC), .MAG_W (5)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .osc_en (osc_en), .cal_sign (cal_sign),
        .cal_mag (cal_mag), .sec_tick (sec_tick), .min_tick (min_tick)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (min_tick && !sec_tick) chk(1'b0, "R3 minute without tick", 0, 1);
            if (sec_tick) begin
                if (sec_idx < 256) sec_len[sec_idx] = cyc - last_tick;
                sec_idx++;
                last_tick = cyc;
                ticks_since_min++;
            end
            if (min_tick) begin
                chk(ticks_since_min == SPM, "R3 ticks per minute", ticks_since_min, SPM);
                ticks_since_min = 0;
                min_cnt++;
                if (min_cnt % MPC == 0) begin
                    cyc_total = cyc - last_end;
                    last_end = cyc;
                    sec_idx = 0;
                    cycles_done++;
                end
            end
        end
    end

    task automatic do_reset(input bit en, input bit sgn, input int mag);
        @(negedge clk);
        rst_n = 1'b0;
        osc_en = en;
        cal_sign = sgn;
        cal_mag = 5'(mag);
        repeat (3) @(negedge clk);
        last_tick = 0; last_end = 0; sec_idx = 0; cycles_done = 0;
        min_cnt = 0; ticks_since_min = 0;
        rst_n = 1'b1;
    endtask

    // Checks one finished period: its total length and every second in it.
    task automatic check_period(input bit sgn, input int mag, input string tag);
        int alt = sgn ? NOM - CUT : NOM + ADD;
        int exp_total = SPC * NOM + 2 * mag * (alt - NOM);
        chk(cyc_total == exp_total, tag, cyc_total, exp_total);
        for (int s = 0; s < SPC; s++) begin
            int m = s / SPM;
            int e = ((s % SPM == 0) && (m < 2 * mag)) ? alt : NOM;
            chk(sec_len[s] == e, (m >= 62) ? "R8 second length" : "R5 second length",
                sec_len[s], e);
        end
    endtask

    task automatic t_reset_state;
        do_reset(1'b1, 1'b0, 0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(sec_tick == 1'b0, "R1 tick in reset", int'(sec_tick), 0);
        chk(min_tick == 1'b0, "R1 minute in reset", int'(min_tick), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sec_tick == 1'b0, "R1 tick after release", int'(sec_tick), 0);
    endtask

    task automatic t_gated_second;
        do_reset(1'b1, 1'b0, 0);
        for (int i = 0; i < 560; i++) begin
            @(negedge clk);
            osc_en = ~osc_en;
        end
        chk(sec_idx == 1, "R2 ticks under gated enable", sec_idx, 1);
        chk(sec_len[0] == 2 * NOM - 1, "R2 gated second length", sec_len[0], 2 * NOM - 1);
    endtask

    task automatic t_reset_capture;
        do_reset(1'b1, 1'b1, 1);
        repeat (10) @(negedge clk);
        cal_sign = 1'b1; cal_mag = 5'd6;
        wait (cycles_done == 1);
        check_period(1'b1, 1, "R1 R9 period from reset capture");
    endtask

    task automatic t_gain_six;
        cal_sign = 1'b0; cal_mag = 5'd31;
        wait (cycles_done == 2);
        check_period(1'b1, 6, "R6 gain period total");
    endtask

    task automatic t_lose_full;
        cal_sign = 1'b1; cal_mag = 5'd0;
        wait (cycles_done == 3);
        check_period(1'b0, 31, "R7 R8 lose period total");
    endtask

    task automatic t_no_trim;
        wait (cycles_done == 4);
        check_period(1'b1, 0, "R4 untrimmed period total");
    endtask

    initial begin
        t_reset_state();
        t_gated_second();
        t_reset_capture();
        t_gain_six();
        t_lose_full();
        t_no_trim();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles_done, 4);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule